// File: doc/BRIEF.md
# Missing-Frame Suspend Detector

This block watches the host's frame markers on a full-speed serial bus link. The host sends a start-of-frame packet about once per millisecond. The block counts ticks of a clock-enable input to measure the time since the last frame marker. If a marker is due and does not arrive, it reports a missed-frame event. If three misses come back to back with no bus traffic between them, it reports a suspend event, so that power management logic can put the link to sleep.

The block also tells whether it has locked to the host's frame timing. It is locked once two frame markers arrive one nominal period apart, within a small tolerance. Missed frames are reported whether or not the block is locked. Packet decoding sits upstream and delivers single-cycle pulses. Everything that follows a suspend event sits downstream.

Top module: `frame_loss_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `esof_o`, `susp_o` and `locked_o` are all 0.
- R2: A frame window is `PERIOD+MARGIN` ticks long. It starts at reset, at an accepted `sof_i`, or at a missed-frame event. When the tick that closes the window arrives without `sof_i`, `esof_o` is 1 for exactly one cycle, in the cycle after that tick's clock edge. An `sof_i` on the closing tick suppresses the event.
- R3: Only cycles with `tick_i` = 1 advance the frame window. Cycles with `tick_i` = 0 do not count.
- R4: Missed-frame events are reported even when `locked_o` is 0, including the first window after reset.
- R5: The elapsed count is the number of ticks since the previous `sof_i`, with the tick of the arriving cycle included. If an `sof_i` arrives with this count in `PERIOD-TOL`..`PERIOD+TOL`, and no missed-frame event has occurred since the previous `sof_i`, then `locked_o` is 1 from the cycle after that `sof_i`. `locked_o` returns to 0 in the cycle after a missed-frame event, or after an `sof_i` that falls outside this range.
- R6: When a missed-frame event is the third in a row with no `sof_i` and no `bus_act_i` since the first, `susp_o` is 1 for one cycle, in the same cycle as that `esof_o` pulse.
- R7: An `sof_i` clears the run of consecutive misses. A `bus_act_i` also clears it. If `bus_act_i` coincides with a closing tick, that miss is counted as the first of a new run.
- R8: After a suspend event the run saturates. Further misses still pulse `esof_o`, but they do not pulse `susp_o` until an `sof_i` or `bus_act_i` clears the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock-enable tick that times the frame window |
| sof_i | input | 1 | One-cycle pulse: start-of-frame packet received |
| bus_act_i | input | 1 | One-cycle pulse: any other bus traffic seen |
| esof_o | output | 1 | One-cycle pulse: expected frame marker missing |
| susp_o | output | 1 | One-cycle pulse: suspend condition detected |
| locked_o | output | 1 | Timer locked to the host frame timing |

## Verification
Every result leaves through one register stage. `esof_o` and `susp_o` rise in the cycle after the clock edge that samples the closing tick. `locked_o` changes in the cycle after the edge that samples the `sof_i` or the miss. With a tick on every cycle, a miss is therefore visible exactly `PERIOD+MARGIN` cycles after the edge that restarted the window. The bench drives its inputs and reads its outputs only on falling edges. It counts those edges from a known restart point, so each check lands on the exact cycle that is due. It reads one cycle early as well, to show that no pulse comes too soon. In the gated-tick case the exact edge depends on the tick pattern, so the bench instead counts pulses over intervals that bracket the window.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    // Per-cycle frame event, produced by the window timer and consumed by
    // the lock tracker, the miss-streak counter and the output stage.
    typedef struct packed {
        logic sof;       // frame marker received this cycle
        logic miss;      // window closed without a marker
        logic on_time;   // marker landed inside the lock tolerance
    } frame_evt_t;

    // State of the run of consecutive misses.
    typedef enum logic [1:0] {
        STREAK_IDLE,
        STREAK_RUN,
        STREAK_SAT
    } streak_e;

    function automatic int unsigned win_len(int unsigned period, int unsigned margin);
        return period + margin;
    endfunction

    function automatic int unsigned bits_for(int unsigned max_value);
        return (max_value < 2) ? 1 : $clog2(max_value + 1);
    endfunction

endpackage

// File: rtl/sfd_frame_timer.sv
module sfd_frame_timer
    import sfd_pkg::*;
#(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned MARGIN = 8,
    parameter int unsigned TOL    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sof,
    output frame_evt_t evt
);
    localparam int unsigned WIN = win_len(PERIOD, MARGIN);
    localparam int unsigned CW  = bits_for(WIN);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);
    localparam logic [CW-1:0] LO   = CW'(PERIOD - TOL);
    localparam logic [CW-1:0] HI   = CW'(PERIOD + TOL);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] elapsed;
    logic          ref_q;    // a marker started the current window
    logic          closing;

    always_comb begin
        elapsed     = cnt_q + CW'(tick);
        closing     = tick && (cnt_q == LAST);
        evt.sof     = sof;
        evt.miss    = closing && !sof;
        evt.on_time = sof && ref_q && (elapsed >= LO) && (elapsed <= HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else if (sof) begin
            cnt_q <= '0;
            ref_q <= 1'b1;
        end else if (closing) begin
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);                                             // R2
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !sof) |=> $stable(cnt_q));                        // R3
    AST_MISS_EXCLUDES_SOF: assert property (@(posedge clk) disable iff (rst)
        evt.miss |-> !evt.sof);                                     // R2

endmodule

// File: rtl/sfd_lock_tracker.sv
module sfd_lock_tracker
    import sfd_pkg::*;
#(
    parameter int unsigned LOCK_SOFS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    output logic       locked
);
    localparam int unsigned NEED = LOCK_SOFS - 1;
    localparam int unsigned GW   = bits_for(NEED);
    localparam logic [GW-1:0] NEED_V = GW'(NEED);

    logic [GW-1:0] good_q;
    logic [GW-1:0] good_d;

    always_comb begin
        good_d = good_q;
        if (evt.miss) begin
            good_d = '0;
        end else if (evt.sof) begin
            if (!evt.on_time)          good_d = '0;
            else if (good_q != NEED_V) good_d = good_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) good_q <= '0;
        else     good_q <= good_d;
    end

    assign locked = (good_q == NEED_V);

    AST_MISS_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        evt.miss |=> !locked);                                      // R5
    AST_LATE_SOF_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (evt.sof && !evt.on_time) |=> !locked);                     // R5
    AST_LOCK_NEEDS_SOF: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(evt.on_time));                      // R5

endmodule

// File: rtl/sfd_miss_counter.sv
module sfd_miss_counter
    import sfd_pkg::*;
#(
    parameter int unsigned MISS_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       activity,
    input  frame_evt_t evt,
    output logic       susp_evt
);
    localparam int unsigned MW = bits_for(MISS_LIMIT);
    localparam logic [MW-1:0] LIMIT_V  = MW'(MISS_LIMIT);
    localparam logic [MW-1:0] BEFORE_V = MW'(MISS_LIMIT - 1);

    logic [MW-1:0] miss_q;
    logic [MW-1:0] miss_d;
    streak_e       state;

    always_comb begin
        if (miss_q == '0)          state = STREAK_IDLE;
        else if (miss_q == LIMIT_V) state = STREAK_SAT;
        else                        state = STREAK_RUN;
    end

    always_comb begin
        miss_d   = miss_q;
        susp_evt = 1'b0;
        if (evt.sof) begin
            miss_d = '0;
        end else if (activity) begin
            miss_d = evt.miss ? MW'(1) : '0;
        end else if (evt.miss && state != STREAK_SAT) begin
            miss_d   = miss_q + 1'b1;
            susp_evt = (miss_q == BEFORE_V);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) miss_q <= '0;
        else     miss_q <= miss_d;
    end

    AST_STREAK_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        miss_q <= LIMIT_V);                                         // R8
    AST_ACTIVITY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (activity && !evt.miss) |=> miss_q == '0);                  // R7
    AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (miss_q == LIMIT_V && !activity && !evt.sof) |=> miss_q == LIMIT_V); // R8
    AST_SUSP_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        susp_evt |-> evt.miss);                                     // R6

endmodule

// File: rtl/frame_loss_monitor.sv
module frame_loss_monitor
    import sfd_pkg::*;
#(
    parameter int unsigned PERIOD     = 1000,
    parameter int unsigned MARGIN     = 8,
    parameter int unsigned TOL        = 4,
    parameter int unsigned LOCK_SOFS  = 2,
    parameter int unsigned MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sof_i,
    input  logic bus_act_i,
    output logic esof_o,
    output logic susp_o,
    output logic locked_o
);
    frame_evt_t evt;
    logic       susp_evt;
    logic       esof_q;
    logic       susp_q;

    sfd_frame_timer #(.PERIOD(PERIOD), .MARGIN(MARGIN), .TOL(TOL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_i),
        .sof  (sof_i),
        .evt  (evt)
    );

    sfd_lock_tracker #(.LOCK_SOFS(LOCK_SOFS)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .locked (locked_o)
    );

    sfd_miss_counter #(.MISS_LIMIT(MISS_LIMIT)) u_streak (
        .clk      (clk),
        .rst      (rst),
        .activity (bus_act_i),
        .evt      (evt),
        .susp_evt (susp_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            esof_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            esof_q <= evt.miss;
            susp_q <= susp_evt;
        end
    end

    assign esof_o = esof_q;
    assign susp_o = susp_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!esof_o && !susp_o && !locked_o));                 // R1
    AST_SUSP_WITH_ESOF: assert property (@(posedge clk) disable iff (rst)
        susp_o |-> esof_o);                                         // R6
    AST_SOF_BLOCKS_ESOF: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> !esof_o);                                         // R2
    AST_ESOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        esof_o |=> !esof_o);                                        // R2

endmodule

// File: tb/frame_loss_monitor_test.sv
module frame_loss_monitor_test;
    localparam int unsigned P  = 20;
    localparam int unsigned M  = 3;
    localparam int unsigned T  = 2;
    localparam int unsigned W  = P + M;   // 23 ticks per window

    typedef struct packed {
        int unsigned gap;     // cycles from previous SOF edge
        logic        lock;    // expected locked_o afterwards
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{20, 1'b1}, '{22, 1'b1}, '{18, 1'b1}, '{17, 1'b0},
        '{20, 1'b1}, '{23, 1'b0}, '{21, 1'b1}, '{19, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic slow = 1'b0;
    logic sof = 1'b0;
    logic act = 1'b0;
    logic esof, susp, locked;

    int n_checks = 0;
    int n_fail = 0;
    int esof_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) tick <= slow ? ~tick : 1'b1;
    always @(posedge clk) if (esof) esof_cnt <= esof_cnt + 1;

    frame_loss_monitor #(.PERIOD(P), .MARGIN(M), .TOL(T), .LOCK_SOFS(2), .MISS_LIMIT(3)) uut (
        .clk(clk), .rst(rst), .tick_i(tick), .sof_i(sof), .bus_act_i(act),
        .esof_o(esof), .susp_o(susp), .locked_o(locked)
    );

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic chk(input string req, input logic a, input logic e);
        check(a === e, req, int'(a), int'(e));
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // leaves the bench at the negedge where rst has just been released
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sof = 1'b0; act = 1'b0;
        wait_n(2);
        chk("R1 esof in reset", esof, 1'b0);
        chk("R1 susp in reset", susp, 1'b0);
        chk("R1 locked in reset", locked, 1'b0);
        rst = 1'b0;
    endtask

    // at a negedge just after an SOF edge: send the next SOF k cycles later
    task automatic sof_after(input int k);
        wait_n(k - 1);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    initial begin
        int base;
        // ---- vector table: SOF spacing vs lock (R5), no spurious ESOF (R2)
        do_reset();
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        chk("R5 first SOF no lock", locked, 1'b0);
        base = esof_cnt;
        for (int i = 0; i < 8; i++) begin
            sof_after(int'(VEC[i].gap));
            chk($sformatf("R5 lock after gap %0d", VEC[i].gap), locked, VEC[i].lock);
        end
        check(esof_cnt == base, "R2 no esof with timely SOF", esof_cnt - base, 0);

        // ---- D1: three misses -> suspend, then saturation (R2 R5 R6 R8)
        wait_n(W - 1);
        chk("R2 no esof before window", esof, 1'b0);
        chk("R5 still locked", locked, 1'b1);
        wait_n(1);
        chk("R2 esof at window close", esof, 1'b1);
        chk("R5 miss drops lock", locked, 1'b0);
        chk("R6 first miss no susp", susp, 1'b0);
        wait_n(1);
        chk("R2 esof one cycle", esof, 1'b0);
        wait_n(W - 1);
        chk("R6 second miss esof", esof, 1'b1);
        chk("R6 second miss no susp", susp, 1'b0);
        wait_n(W);
        chk("R6 third miss esof", esof, 1'b1);
        chk("R6 third miss susp", susp, 1'b1);
        wait_n(W);
        chk("R8 fourth miss esof", esof, 1'b1);
        chk("R8 saturated no susp", susp, 1'b0);

        // ---- D2: activity clears streak, coincident activity counts as first (R7)
        wait_n(8);
        act = 1'b1;
        @(negedge clk);
        act = 1'b0;
        wait_n(14);
        chk("R7 esof after activity", esof, 1'b1);
        chk("R7 restart streak 1", susp, 1'b0);
        wait_n(W);
        chk("R7 streak 2 no susp", susp, 1'b0);
        wait_n(W - 1);
        act = 1'b1;
        @(negedge clk);
        act = 1'b0;
        chk("R7 coincident miss esof", esof, 1'b1);
        chk("R7 coincident activity no susp", susp, 1'b0);
        wait_n(W);
        chk("R7 streak 2 after coincident", susp, 1'b0);
        wait_n(W);
        chk("R8 susp resumes after clear", susp, 1'b1);

        // ---- D3: misses before lock, SOF clears streak (R4 R7)
        do_reset();
        wait_n(W);
        chk("R4 esof before lock", esof, 1'b1);
        chk("R4 unlocked", locked, 1'b0);
        wait_n(W);
        chk("R4 second esof", esof, 1'b1);
        wait_n(4);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        wait_n(W);
        chk("R7 esof after SOF", esof, 1'b1);
        chk("R7 SOF cleared streak", susp, 1'b0);
        wait_n(W);
        chk("R7 streak 2 after SOF", susp, 1'b0);
        wait_n(W);
        chk("R7 susp on third after SOF", susp, 1'b1);

        // ---- D4: gated ticks stretch the window (R3)
        slow = 1'b1;
        do_reset();
        base = esof_cnt;
        wait_n(W + 2);
        check(esof_cnt == base, "R3 no esof before enough ticks", esof_cnt - base, 0);
        wait_n(30);
        check(esof_cnt == base + 1, "R3 one esof after enough ticks", esof_cnt - base, 1);
        slow = 1'b0;

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule